// File: doc/BRIEF.md
# Over-Current Fault Recovery Sequencer

This block sits between the fault comparators of a three-phase bridge driver and its gate logic. It receives four fault flags: a hard over-current trip, a control-supply undervoltage flag, a high-side (bootstrap) supply undervoltage flag and an over-temperature flag. It turns them into three commands for the gate logic. The first switches every transistor of the bridge off. The second blocks only the high-side switches. The third is a per-phase low-side refresh enable.

An over-current trip does not clear at once. The sequencer first holds the bridge off for a timed off period. It then enters a refresh phase. In that phase every high side is blocked, and the low side of the phase whose high side the commutation logic currently selects is switched on, so that the bootstrap capacitor of that phase charges. Only then does the bridge return to normal commutation.

The total recovery length is one parameter in clock cycles. The refresh share of it is derived at a fixed ratio of 21/106, and an elaboration check enforces a minimum refresh length. The undervoltage and thermal flags already carry hysteresis. Each is qualified by a short debounce counter and acts as a level for as long as it stays qualified.

Top module: `fault_recovery_seq`

## Requirements
- R1: After reset the sequence state is RUN (status code 0), and `all_off_o`, `hs_block_o` and `refresh_ls_o` are all zero.
- R2: `oc_trip_i` sampled high at a clock edge puts the sequencer in OFF (status code 1) from that edge, with `all_off_o` high, in any state.
- R3: Without a new trip, OFF lasts exactly OFF_CYC = RECOVERY_CYC − REFRESH_CYC cycles (425 by default) and is always followed by REFRESH (status code 2).
- R4: REFRESH lasts exactly REFRESH_CYC = floor(RECOVERY_CYC·21/106) cycles (105 by default). During it `hs_block_o` is 1, `all_off_o` is 0 unless a supply or thermal fault is qualified, and `refresh_ls_o` equals `hs_phase_i` (bit i = phase i).
- R5: After REFRESH the state returns to RUN and stays there until the next trip. In RUN, `refresh_ls_o` is zero.
- R6: A trip arriving during OFF or REFRESH restarts a full OFF period from its first cycle.
- R7: `vcc_low_i` becomes qualified after DEB_CYC (4) consecutive high samples and clears after DEB_CYC consecutive low samples. While it is qualified, `all_off_o` is 1. Shorter pulses have no effect.
- R8: `hot_i` is qualified in the same way as in R7 and also forces `all_off_o` while it is qualified.
- R9: `vboot_low_i`, once qualified as in R7, sets `hs_block_o` and leaves `all_off_o` unaffected.
- R10: A qualified control-supply or thermal fault forces `refresh_ls_o` to zero during REFRESH without altering the sequence timing.
- R11: With a one-hot or zero `hs_phase_i`, `refresh_ls_o` is one-hot or zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| oc_trip_i | input | 1 | Hard over-current comparator flag |
| vcc_low_i | input | 1 | Control-supply undervoltage flag (hysteresis applied) |
| vboot_low_i | input | 1 | High-side supply undervoltage flag |
| hot_i | input | 1 | Over-temperature flag |
| hs_phase_i | input | PHASES | One-hot phase whose high side commutation selects |
| all_off_o | output | 1 | Force every bridge switch off |
| hs_block_o | output | 1 | Force all high-side switches off |
| refresh_ls_o | output | PHASES | Low-side refresh enable per phase |
| seq_state_o | output | 2 | Sequence state: 0 RUN, 1 OFF, 2 REFRESH |

## Verification
The hardest situations to reach from the ports are a second trip landing inside the refresh window, and a supply fault qualifying just as refresh begins. Random stimulus rarely lines either up. Directed sequences therefore count cycles from a single trip pulse to place the second trip in mid-refresh and to raise the undervoltage flag exactly at the refresh boundary. After these, seeded random stimulus drives sparse trips and flags that toggle at varying rates, so that both sub-threshold glitches and qualifying runs occur. Every cycle is compared against a reference model in the bench.

// File: rtl/fault_seq_pkg.sv
package fault_seq_pkg;
   typedef enum logic [1:0] {
      ST_RUN     = 2'd0,
      ST_OFF     = 2'd1,
      ST_REFRESH = 2'd2
   } seq_state_t;

   localparam int FLAG_VCC   = 0;
   localparam int FLAG_VBOOT = 1;
   localparam int FLAG_HOT   = 2;
   localparam int NUM_FLAGS  = 3;

   localparam int REFRESH_NUM = 21;
   localparam int REFRESH_DEN = 106;
endpackage

// File: rtl/flag_qualify.sv
module flag_qualify #(
   parameter int DEB_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic raw_i,
   output logic q_o
);
   localparam int CW = (DEB_CYC > 1) ? $clog2(DEB_CYC) : 1;
   localparam logic [CW-1:0] CNT_LAST = CW'(DEB_CYC - 1);

   if (DEB_CYC < 1) begin : g_bad_deb
      $error("flag_qualify: DEB_CYC must be at least 1");
   end

   logic [CW-1:0] run_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_o     <= 1'b0;
         run_cnt <= '0;
      end else if (raw_i == q_o) begin
         run_cnt <= '0;
      end else if (run_cnt == CNT_LAST) begin
         q_o     <= raw_i;
         run_cnt <= '0;
      end else begin
         run_cnt <= run_cnt + 1'b1;
      end
   end

   // R7: an input that agrees with the qualified level never moves it
   p_hold_level_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (raw_i == q_o) |=> $stable(q_o));
endmodule

// File: rtl/recovery_fsm.sv
module recovery_fsm
   import fault_seq_pkg::*;
#(
   parameter int OFF_CYC     = 425,
   parameter int REFRESH_CYC = 105
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip_i,
   output seq_state_t state_o
);
   localparam int LONGEST = (OFF_CYC > REFRESH_CYC) ? OFF_CYC : REFRESH_CYC;
   localparam int CW      = $clog2(LONGEST + 1);
   localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);
   localparam logic [CW-1:0] REF_LAST = CW'(REFRESH_CYC - 1);

   seq_state_t    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_RUN;
         cnt   <= '0;
      end else if (trip_i) begin
         state <= ST_OFF;
         cnt   <= '0;
      end else begin
         unique case (state)
            ST_OFF: begin
               if (cnt == OFF_LAST) begin
                  state <= ST_REFRESH;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_REFRESH: begin
               if (cnt == REF_LAST) begin
                  state <= ST_RUN;
                  cnt   <= '0;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: begin
               state <= ST_RUN;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign state_o = state;

   // R2, R6: a trip always lands in OFF on the next cycle
   p_trip_to_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trip_i |=> (state == ST_OFF));
   // R3: OFF never returns straight to RUN
   p_off_no_skip_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_OFF && !trip_i) |=> (state != ST_RUN));
   // R4: REFRESH is left only towards RUN when no trip arrives
   p_refresh_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_REFRESH && !trip_i) |=> (state != ST_OFF));
   // R5: RUN is kept until a trip
   p_run_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUN && !trip_i) |=> (state == ST_RUN));
endmodule

// File: rtl/fault_recovery_seq.sv
module fault_recovery_seq
   import fault_seq_pkg::*;
#(
   parameter int PHASES          = 3,
   parameter int RECOVERY_CYC    = 530,
   parameter int MIN_REFRESH_CYC = 16,
   parameter int DEB_CYC         = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              oc_trip_i,
   input  logic              vcc_low_i,
   input  logic              vboot_low_i,
   input  logic              hot_i,
   input  logic [PHASES-1:0] hs_phase_i,
   output logic              all_off_o,
   output logic              hs_block_o,
   output logic [PHASES-1:0] refresh_ls_o,
   output logic [1:0]        seq_state_o
);
   localparam int REFRESH_CYC = (RECOVERY_CYC * REFRESH_NUM) / REFRESH_DEN;
   localparam int OFF_CYC     = RECOVERY_CYC - REFRESH_CYC;

   if (REFRESH_CYC < MIN_REFRESH_CYC) begin : g_bad_refresh
      $error("fault_recovery_seq: refresh share shorter than MIN_REFRESH_CYC");
   end
   if (OFF_CYC < 1) begin : g_bad_off
      $error("fault_recovery_seq: off period must be at least one cycle");
   end
   if (PHASES < 1) begin : g_bad_phases
      $error("fault_recovery_seq: PHASES must be at least 1");
   end

   logic [NUM_FLAGS-1:0] flags_raw;
   logic [NUM_FLAGS-1:0] flags_q;
   seq_state_t           state;

   assign flags_raw[FLAG_VCC]   = vcc_low_i;
   assign flags_raw[FLAG_VBOOT] = vboot_low_i;
   assign flags_raw[FLAG_HOT]   = hot_i;

   for (genvar f = 0; f < NUM_FLAGS; f++) begin : g_qual
      flag_qualify #(.DEB_CYC(DEB_CYC)) u_qual (
         .clk   (clk),
         .rst_n (rst_n),
         .raw_i (flags_raw[f]),
         .q_o   (flags_q[f])
      );
   end

   recovery_fsm #(
      .OFF_CYC     (OFF_CYC),
      .REFRESH_CYC (REFRESH_CYC)
   ) u_fsm (
      .clk     (clk),
      .rst_n   (rst_n),
      .trip_i  (oc_trip_i),
      .state_o (state)
   );

   logic supply_dead;
   assign supply_dead = flags_q[FLAG_VCC] | flags_q[FLAG_HOT];

   always_comb begin
      all_off_o    = supply_dead | (state == ST_OFF);
      hs_block_o   = flags_q[FLAG_VBOOT] | (state == ST_REFRESH);
      refresh_ls_o = '0;
      if (state == ST_REFRESH && !supply_dead) begin
         refresh_ls_o = hs_phase_i;
      end
   end

   assign seq_state_o = state;

   // R7, R8: a qualified supply or thermal fault always forces the bridge off
   p_dead_forces_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      supply_dead |-> all_off_o);
   // R4: refresh enables only appear in REFRESH with the high side blocked
   p_refresh_in_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (refresh_ls_o != '0) |-> (seq_state_o == 2'd2 && hs_block_o && !all_off_o));
   // R11: one-hot phase selection yields one-hot refresh
   p_refresh_onehot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hs_phase_i) |-> $onehot0(refresh_ls_o));
endmodule

// File: tb/fault_recovery_seq_bench.sv
module fault_recovery_seq_bench;
   localparam int PHASES   = 3;
   localparam int RECOVERY = 530;
   localparam int DEB      = 4;
   localparam int REF_CYC  = (RECOVERY * 21) / 106;
   localparam int OFF_CYC  = RECOVERY - REF_CYC;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              oc = 1'b0, vcc = 1'b0, vboot = 1'b0, hot = 1'b0;
   logic [PHASES-1:0] hs = 3'b001;
   logic              all_off, hs_block;
   logic [PHASES-1:0] rls;
   logic [1:0]        st;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #4 clk = ~clk;

   fault_recovery_seq #(
      .PHASES(PHASES), .RECOVERY_CYC(RECOVERY), .MIN_REFRESH_CYC(16), .DEB_CYC(DEB)
   ) u_fault_recovery_seq (
      .clk(clk), .rst_n(rst_n), .oc_trip_i(oc), .vcc_low_i(vcc),
      .vboot_low_i(vboot), .hot_i(hot), .hs_phase_i(hs),
      .all_off_o(all_off), .hs_block_o(hs_block), .refresh_ls_o(rls),
      .seq_state_o(st)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model built from the requirements
   int m_state = 0;
   int m_left  = 0;
   bit m_q[3];
   int m_run[3];

   function automatic bit exp_all_off();
      return m_q[0] | m_q[2] | (m_state == 1);
   endfunction
   function automatic bit exp_hs_block();
      return m_q[1] | (m_state == 2);
   endfunction
   function automatic int exp_rls(input logic [PHASES-1:0] ph);
      return (m_state == 2 && !(m_q[0] | m_q[2])) ? int'(ph) : 0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_state <= 0; m_left <= 0;
         for (int i = 0; i < 3; i++) begin m_q[i] <= 1'b0; m_run[i] <= 0; end
      end else begin
         bit raw[3];
         raw[0] = vcc; raw[1] = vboot; raw[2] = hot;
         for (int i = 0; i < 3; i++) begin
            if (raw[i] == m_q[i]) m_run[i] <= 0;
            else if (m_run[i] == DEB - 1) begin m_q[i] <= raw[i]; m_run[i] <= 0; end
            else m_run[i] <= m_run[i] + 1;
         end
         if (oc) begin m_state <= 1; m_left <= OFF_CYC; end
         else if (m_state == 1) begin
            if (m_left == 1) begin m_state <= 2; m_left <= REF_CYC; end
            else m_left <= m_left - 1;
         end else if (m_state == 2) begin
            if (m_left == 1) m_state <= 0;
            else m_left <= m_left - 1;
         end
      end
   end

   bit model_on = 1'b0;
   always @(negedge clk) begin
      if (model_on && rst_n && !done) begin
         chk("R11 model state", st, m_state);
         chk("R7 R8 model all_off", all_off, exp_all_off());
         chk("R9 model hs_block", hs_block, exp_hs_block());
         chk("R10 model refresh_ls", rls, exp_rls(hs));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   // pulse oc for one cycle, leaving the bench just after the trip edge's negedge
   task automatic trip();
      @(negedge clk); #1 oc = 1'b1;
      @(negedge clk); #1 oc = 1'b0;
   endtask

   initial begin
      int n;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1 reset state", st, 0);
      chk("R1 reset all_off", all_off, 0);
      chk("R1 reset hs_block", hs_block, 0);
      chk("R1 reset refresh", rls, 0);
      model_on = 1'b1;

      // full sequence with a single trip
      hs = 3'b010;
      trip();
      chk("R2 off after trip", st, 1);
      chk("R2 all_off after trip", all_off, 1);
      n = 1;
      while (st == 1 && n < 2000) begin @(negedge clk); if (st == 1) n++; end
      chk("R3 off length", n, OFF_CYC);
      chk("R3 next state refresh", st, 2);
      chk("R4 refresh hs_block", hs_block, 1);
      chk("R4 refresh all_off", all_off, 0);
      chk("R4 refresh low side", rls, 3'b010);
      n = 0;
      while (st == 2 && n < 2000) begin @(negedge clk); n++; end
      chk("R4 refresh length", n, REF_CYC);
      chk("R5 back to run", st, 0);
      chk("R5 no refresh in run", rls, 0);
      repeat (20) @(negedge clk);
      chk("R5 run holds", st, 0);

      // second trip in the middle of refresh restarts the sequence
      trip();
      repeat (OFF_CYC + 50) @(negedge clk);
      chk("R6 mid refresh", st, 2);
      trip();
      chk("R6 restart off", st, 1);
      n = 1;
      while (st == 1 && n < 2000) begin @(negedge clk); if (st == 1) n++; end
      chk("R6 full off again", n, OFF_CYC);

      // control-supply fault rising at the refresh boundary
      hs = 3'b100;
      #1 vcc = 1'b1;
      repeat (DEB - 1) begin
         @(negedge clk);
      end
      chk("R7 not yet qualified refresh", rls, 3'b100);
      @(negedge clk);
      chk("R10 refresh suppressed", rls, 0);
      chk("R10 state kept", st, 2);
      chk("R7 all_off qualified", all_off, 1);
      #1 vcc = 1'b0;
      while (st != 0) @(negedge clk);

      // glitch of DEB-1 samples is ignored
      #1 vcc = 1'b1;
      repeat (DEB - 1) @(negedge clk);
      #1 vcc = 1'b0;
      repeat (DEB + 1) begin @(negedge clk); chk("R7 glitch ignored", all_off, 0); end

      // thermal flag
      #1 hot = 1'b1;
      repeat (DEB) @(negedge clk);
      chk("R8 hot forces off", all_off, 1);
      #1 hot = 1'b0;
      repeat (DEB - 1) @(negedge clk);
      chk("R8 hot held until low run", all_off, 1);
      @(negedge clk);
      chk("R8 hot released", all_off, 0);

      // high-side supply flag
      #1 vboot = 1'b1;
      repeat (DEB) @(negedge clk);
      chk("R9 vboot blocks high side", hs_block, 1);
      chk("R9 vboot leaves all_off", all_off, 0);
      #1 vboot = 1'b0;
      repeat (DEB) @(negedge clk);
      chk("R9 vboot released", hs_block, 0);

      // random phase, compared against the model every cycle
      for (int c = 0; c < 20000; c++) begin
         @(negedge clk);
         #1;
         oc    = ($urandom_range(0, 399) == 0);
         if ($urandom_range(0, 29) == 0) vcc   = ~vcc;
         if ($urandom_range(0, 19) == 0) vboot = ~vboot;
         if ($urandom_range(0, 49) == 0) hot   = ~hot;
         if ($urandom_range(0, 9) == 0)  hs    = 3'(1 << $urandom_range(0, 2));
      end
      @(negedge clk);
      finish_run();
   end
endmodule